// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides a clock running at the VCO-derived rate by a programmable ratio N = 16·A + B and emits a one-clock pulse, fv, that the phase comparator sets against the reference. A 16/17 dual-modulus prescaler is modelled as a small counter. A period counter and a swallow comparison drive its modulus-control line. The prescaler runs at 17 for the first B prescaler periods of each output period and at 16 for the rest, so the ratio is 17·B + 16·(A − B).

Software writes A as A − 1 into a 9-bit field, and the block adds the one back. B is a 4-bit value. Both are sampled only on the cycle in which a new output period begins, so a write made in the middle of a period never shortens or stretches that period.

Top module: `pss_fb_divider`

## Requirements
- R1: While rst_ni is low, fv_o is low. After release, the first fv_o pulse appears on the N-th rising edge, where N is the ratio programmed at release.
- R2: The effective main count A equals a_field_i + 1, so a_field_i = 0 yields A = 1 and a ratio of at least 16.
- R3: For B ≤ A, consecutive fv_o pulses are exactly 16·A + B clock cycles apart.
- R4: fv_o is high for exactly one clock cycle per output period.
- R5: mod_o (1 = divide by 17) is high for exactly 17·min(A, B) cycles in each output period. It changes level only on the cycle after a prescaler period ends.
- R6: With b_val_i = 0, mod_o stays low, the ratio is 16·A, and no extra pulse appears.
- R7: A new a_field_i or b_val_i applied mid-period leaves the current period's length unchanged and takes effect from the following period.
- R8: If B > A, every one of the A prescaler periods runs at 17, giving a ratio of 17·A.
- R9: a_field_i = 12 with b_val_i = 4 gives A = 13, B = 4 and one fv_o pulse every 212 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divider input clock (prescaler-rate model) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_field_i | input | 9 | Main count stored as A − 1 |
| b_val_i | input | 4 | Swallow count B, 0 to 15 |
| fv_o | output | 1 | One-cycle feedback pulse, once per N cycles |
| mod_o | output | 1 | Modulus control, 1 selects divide by 17 |

## Verification
fv_o is registered, so it rises on the N-th rising edge after the start of a period, including the first period after reset. The bench samples every output at the falling edge and counts falling edges from reset release, or from the previous pulse, to the next high sample. mod_o is combinational from the counter state, so it is sampled on those same falling edges and summed over one full period. For the mid-period update, new values are driven at a falling edge well inside a period. The bench then expects the old spacing for the current period and the new spacing for the period after it.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned PRE_MOD   = 16;
  localparam int unsigned PRE_W     = $clog2(PRE_MOD + 1);
  localparam int unsigned A_FIELD_W = 9;
  localparam int unsigned A_W       = A_FIELD_W + 1;
  localparam int unsigned B_W       = $clog2(PRE_MOD);
endpackage

// File: rtl/pss_prescaler.sv
module pss_prescaler #(
  parameter int unsigned MOD = pss_pkg::PRE_MOD,
  parameter int unsigned W   = pss_pkg::PRE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mod_i,
  output logic tc_o
);
  localparam logic [W-1:0] LIM_LO = W'(MOD - 1);
  localparam logic [W-1:0] LIM_HI = W'(MOD);

  logic [W-1:0] cnt_q;

  assign tc_o = (cnt_q == (mod_i ? LIM_HI : LIM_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tc_o) cnt_q <= '0;
    else           cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pss_period_ctrl.sv
module pss_period_ctrl #(
  parameter int unsigned A_FIELD_W = pss_pkg::A_FIELD_W,
  parameter int unsigned A_W       = pss_pkg::A_W,
  parameter int unsigned B_W       = pss_pkg::B_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tc_i,
  input  logic [A_FIELD_W-1:0] a_field_i,
  input  logic [B_W-1:0]       b_val_i,
  output logic                 mod_o,
  output logic                 term_o
);
  logic           start_q;
  logic [A_W-1:0] a_q, prd_q, a_eff, last_idx;
  logic [B_W-1:0] b_q, b_eff;

  // period start uses live inputs so a change lands only on a boundary
  assign a_eff    = start_q ? (A_W'(a_field_i) + A_W'(1)) : a_q;
  assign b_eff    = start_q ? b_val_i : b_q;
  assign last_idx = a_eff - A_W'(1);
  assign mod_o    = (prd_q < A_W'(b_eff));
  assign term_o   = tc_i && (prd_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      a_q     <= A_W'(1);
      b_q     <= '0;
      prd_q   <= '0;
    end else begin
      start_q <= term_o;
      if (start_q) begin
        a_q <= a_eff;
        b_q <= b_eff;
      end
      if (tc_i) prd_q <= term_o ? '0 : prd_q + A_W'(1);
    end
  end
endmodule

// File: rtl/pss_fb_divider.sv
module pss_fb_divider #(
  parameter int unsigned A_FIELD_W = pss_pkg::A_FIELD_W,
  parameter int unsigned B_W       = pss_pkg::B_W,
  parameter int unsigned PRE_MOD   = pss_pkg::PRE_MOD
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [A_FIELD_W-1:0] a_field_i,
  input  logic [B_W-1:0]       b_val_i,
  output logic                 fv_o,
  output logic                 mod_o
);
  localparam int unsigned A_W   = A_FIELD_W + 1;
  localparam int unsigned PRE_W = $clog2(PRE_MOD + 1);

  logic pre_tc;
  logic term;

  pss_prescaler #(.MOD(PRE_MOD), .W(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mod_i (mod_o),
    .tc_o  (pre_tc)
  );

  pss_period_ctrl #(.A_FIELD_W(A_FIELD_W), .A_W(A_W), .B_W(B_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tc_i     (pre_tc),
    .a_field_i(a_field_i),
    .b_val_i  (b_val_i),
    .mod_o    (mod_o),
    .term_o   (term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fv_o <= 1'b0;
    else         fv_o <= term;
  end
endmodule

// File: rtl/pss_fb_divider_chk.sv
module pss_fb_divider_chk #(
  parameter int unsigned B_W = pss_pkg::B_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [B_W-1:0] b_val_i,
  input logic           fv_o,
  input logic           mod_o,
  input logic           pre_tc_i
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !fv_o); // R1
  AST_FV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) fv_o |=> !fv_o); // R4
  AST_FV_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni) fv_o |-> $past(pre_tc_i)); // R3
  AST_MOD_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(mod_o) |-> $past(pre_tc_i)); // R5
  AST_NO_SWALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (fv_o && b_val_i == '0) |-> !mod_o); // R6
endmodule

bind pss_fb_divider pss_fb_divider_chk #(.B_W(B_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .b_val_i (b_val_i),
  .fv_o    (fv_o),
  .mod_o   (mod_o),
  .pre_tc_i(pre_tc)
);

// File: tb/tb_pss_fb_divider.sv
module tb_pss_fb_divider;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;

  typedef struct packed {
    logic [8:0]  af;
    logic [3:0]  b;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{9'd12,  4'd4,  16'd212},
    '{9'd0,   4'd0,  16'd16},
    '{9'd0,   4'd1,  16'd17},
    '{9'd3,   4'd2,  16'd66},
    '{9'd7,   4'd8,  16'd136},
    '{9'd2,   4'd15, 16'd51},
    '{9'd20,  4'd15, 16'd351},
    '{9'd63,  4'd0,  16'd1024},
    '{9'd511, 4'd15, 16'd8207}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] a_field = '0;
  logic [3:0] b_val = '0;
  logic       fv, mod_c;
  int         errors = 0;
  int         checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pss_fb_divider dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_field_i(a_field), .b_val_i(b_val),
    .fv_o(fv), .mod_o(mod_c)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [8:0] af, input logic [3:0] b);
    @(negedge clk);
    rst_ni = 1'b0; a_field = af; b_val = b;
    repeat (2) @(negedge clk);
    check(fv == 1'b0, "R1 reset fv", int'(fv), 0);
    rst_ni = 1'b1;
  endtask

  // falling edges from now until fv is sampled high
  task automatic wait_fv(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!fv && k < LIMIT);
  endtask

  // called with fv sampled high; returns spacing, mod-high count, width flag
  task automatic measure(output int len, output int mods, output bit wide);
    len = 0; mods = 0; wide = 1'b0;
    do begin
      if (mod_c) mods++;
      len++;
      @(negedge clk);
      if (len == 1 && fv) wide = 1'b1;
    end while (!fv && len < LIMIT);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k, len, mods, a, bb, mexp;
    bit wide;
    string tag;
    for (int i = 0; i < NV; i++) begin
      a  = int'(VECS[i].af) + 1;
      bb = int'(VECS[i].b);
      mexp = 17 * ((bb < a) ? bb : a);
      // ratio computed from R2/R3/R8 and compared with the table
      check(int'(VECS[i].n) == ((bb > a) ? 17 * a : 16 * a + bb), "R2 table", int'(VECS[i].n), 16 * a + bb);
      tag = (VECS[i].af == 9'd12) ? "R9" : (bb > a) ? "R8" : (bb == 0) ? "R6" : "R3";
      do_reset(VECS[i].af, VECS[i].b);
      wait_fv(k);
      check(k == int'(VECS[i].n), "R1 first pulse", k, int'(VECS[i].n));
      for (int p = 0; p < 2; p++) begin
        measure(len, mods, wide);
        check(len == int'(VECS[i].n), {tag, " spacing"}, len, int'(VECS[i].n));
        check(!wide, "R4 width", int'(wide), 0);
        check(mods == mexp, "R5 mod count", mods, mexp);
      end
    end

    // R7: mid-period update applies from the following period
    do_reset(9'd12, 4'd4);
    wait_fv(k);
    len = 0;
    do begin
      len++;
      @(negedge clk);
      if (len == 50) begin a_field = 9'd0; b_val = 4'd0; end
    end while (!fv && len < LIMIT);
    check(len == 212, "R7 current period", len, 212);
    measure(len, mods, wide);
    check(len == 16, "R7 next period", len, 16);
    check(mods == 0, "R7 R6 no swallow", mods, 0);

    // R1: reset in the middle of a period restarts the count
    a_field = 9'd3; b_val = 4'd2;
    repeat (30) @(negedge clk);
    do_reset(9'd3, 4'd2);
    wait_fv(k);
    check(k == 66, "R1 restart", k, 66);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule